// File: doc/BRIEF.md
# Nested Hardware Loop Sequencer

This block runs zero-overhead loops for a small processor core. The decoder issues a loop command with a start address, an end address and, for a counted loop, a pass count. A second form of the command starts a loop that never ends on a count. On every fetch the sequencer compares the fetch address with the end address of the innermost active loop. It then tells the fetch unit either to jump back to the loop start or to continue past the end.

The state of the enclosing loop is saved on a small internal stack. That state is the start address, the end address, the remaining count, the loop-active flag and the endless flag. It is put back when the inner loop finishes or is aborted, so loops can nest. A return from interrupt also pops the stack, but it restores only the two flags.

A compatibility-mode bit changes how a count is read. In normal mode all counter bits are used and zero means "skip the body". In compatibility mode only the low 16 bits are used and zero means 65536 passes. A write to that bit affects loop commands only three cycles later.

Top module: `hwloop_seq`

## Requirements
- R1: After reset, the loop and endless flags, the current end address, the count, the overflow flag and the effective compatibility bit are all 0, and no branch, skip or exit is signalled.
- R2: A loop command with `do_forever_i=1` sets both flags, loads `do_start_i`/`do_end_i` and loads a count of 0 in the next cycle. Such a loop never exits on a count.
- R3: A loop command pushes the current start, end, count and both flags onto the stack. Every pop except a return from interrupt restores all five, so an outer loop resumes exactly where it was.
- R4: When the loop flag is 1, `fetch_en_i` is 1 and `pc_i` equals the current end address, a branch is raised with `branch_addr_o` equal to the loop start if the loop is endless or its count is above 1. A counted loop's count then drops by one.
- R5: On the same end match in a counted loop whose count is 1 or less, `exit_o` is raised instead of a branch, and the stack is popped.
- R6: In normal mode, a counted loop command with a count of 0 raises `skip_o` with `skip_addr_o = do_end_i + 1`. It leaves every flag, address, count and the stack unchanged.
- R7: In normal mode, the count is loaded with all 24 bits; 0xFFFFFF gives 2^24-1 passes.
- R8: In compatibility mode only the low 16 bits are loaded. 0 loads 65536 and runs that many passes, and 0xFFFFFF loads 65535.
- R9: A write on `compat_wr_i` in cycle n changes the mode used by loop commands, and `compat_eff_o`, from cycle n+3 on.
- R10: A loop command issued while the stack holds DEPTH entries still starts the loop, discards the saved state, and sets `overflow_o`. The flag stays set until reset.
- R11: `abort_i` ends the current loop at once and restores the outer loop through a pop.
- R12: `rti_i` pops the stack and restores only the loop and endless flags. The current start, end and count stay as they were.
- R13: One action per cycle, with priority loop command > abort > return from interrupt > end match. A pop on an empty stack restores all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_en_i | input | 1 | A fetch happens this cycle at `pc_i` |
| pc_i | input | AW | Fetch address |
| do_req_i | input | 1 | Loop command |
| do_forever_i | input | 1 | Loop command is endless |
| do_start_i | input | AW | First address of the loop body |
| do_end_i | input | AW | Last address of the loop body |
| do_count_i | input | CW | Raw pass count |
| abort_i | input | 1 | End the current loop early |
| rti_i | input | 1 | Return from interrupt: pop flags |
| compat_wr_i | input | 1 | Write the compatibility bit |
| compat_val_i | input | 1 | Value written to the compatibility bit |
| branch_o | output | 1 | Jump back to the loop start |
| branch_addr_o | output | AW | Target of the jump |
| skip_o | output | 1 | Skip a zero-count loop body |
| skip_addr_o | output | AW | First address after the skipped body |
| exit_o | output | 1 | Last pass done, fall through |
| loop_flag_o | output | 1 | A loop is active |
| forever_flag_o | output | 1 | The active loop is endless |
| cur_end_o | output | AW | End address of the active loop |
| cur_cnt_o | output | CW | Remaining passes of the active loop |
| compat_eff_o | output | 1 | Compatibility bit now in effect |
| overflow_o | output | 1 | Sticky stack overflow |

## Verification
The bench builds the block with a 16-bit address, a 24-bit count, a mode delay of 3 and a stack of only 4 entries. The small stack lets random nesting overflow it and also pop it empty. The 24-bit count lets one compatibility-mode loop with a zero count run its full 65536 passes within the cycle budget. The normal-mode extreme count is checked on its load and first decrement only.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

  // What the sequencer does in one cycle; exactly one per cycle.
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_START,
    ACT_SKIP,
    ACT_ABORT,
    ACT_RTI,
    ACT_BRANCH,
    ACT_EXIT
  } hwl_act_e;

endpackage

// File: rtl/hwloop_stack.sv
module hwloop_stack #(
  parameter int W     = 58,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic         pop_i,
  input  logic [W-1:0] push_data_i,
  output logic [W-1:0] top_data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int SPW = $clog2(DEPTH + 1);
  localparam int IW  = $clog2(DEPTH);

  logic [W-1:0]   mem [DEPTH];
  logic [SPW-1:0] sp_q;
  logic [SPW-1:0] sp_dec;
  logic [IW-1:0]  top_idx;
  logic [IW-1:0]  wr_idx;

  assign full_o  = (sp_q == SPW'(DEPTH));
  assign empty_o = (sp_q == '0);
  assign sp_dec  = sp_q - 1'b1;
  assign top_idx = sp_dec[IW-1:0];
  assign wr_idx  = sp_q[IW-1:0];

  // An empty stack reads as all zeros, so a pop there clears the state.
  assign top_data_o = empty_o ? '0 : mem[top_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp_q <= '0;
    end else if (push_i && !full_o) begin
      sp_q <= sp_q + 1'b1;
    end else if (pop_i && !empty_o) begin
      sp_q <= sp_dec;
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !full_o) begin
      mem[wr_idx] <= push_data_i;
    end
  end
endmodule

// File: rtl/hwloop_mode_dly.sv
module hwloop_mode_dly #(
  parameter int DLY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_i,
  input  logic val_i,
  output logic eff_o
);
  // Stage 0 holds the written value; later stages age it one cycle each.
  logic [DLY-1:0] stage_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stage_q[0] <= 1'b0;
    end else if (wr_i) begin
      stage_q[0] <= val_i;
    end
  end

  for (genvar g = 1; g < DLY; g++) begin : g_age
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage_q[g] <= 1'b0;
      end else begin
        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign eff_o = stage_q[DLY-1];
endmodule

// File: rtl/hwloop_seq.sv
module hwloop_seq
  import hwloop_pkg::*;
#(
  parameter int AW       = 16,
  parameter int CW       = 24,
  parameter int KW       = 16,
  parameter int DEPTH    = 8,
  parameter int MODE_DLY = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fetch_en_i,
  input  logic [AW-1:0] pc_i,
  input  logic          do_req_i,
  input  logic          do_forever_i,
  input  logic [AW-1:0] do_start_i,
  input  logic [AW-1:0] do_end_i,
  input  logic [CW-1:0] do_count_i,
  input  logic          abort_i,
  input  logic          rti_i,
  input  logic          compat_wr_i,
  input  logic          compat_val_i,
  output logic          branch_o,
  output logic [AW-1:0] branch_addr_o,
  output logic          skip_o,
  output logic [AW-1:0] skip_addr_o,
  output logic          exit_o,
  output logic          loop_flag_o,
  output logic          forever_flag_o,
  output logic [AW-1:0] cur_end_o,
  output logic [CW-1:0] cur_cnt_o,
  output logic          compat_eff_o,
  output logic          overflow_o
);
  localparam int EW = 2 * AW + CW + 2;
  localparam logic [CW-1:0] WRAP_CNT = {{(CW-1){1'b0}}, 1'b1} << KW;

  // Count actually loaded for a counted loop.
  function automatic logic [CW-1:0] load_count(input logic [CW-1:0] raw, input logic cm);
    logic [KW-1:0] low;
    low = raw[KW-1:0];
    if (!cm) return raw;
    if (low == '0) return WRAP_CNT;
    return CW'(low);
  endfunction

  // A zero count skips the body only in normal mode.
  function automatic logic zero_skips(input logic [CW-1:0] raw, input logic cm);
    return !cm && (raw == '0);
  endfunction

  // Current loop context
  logic [AW-1:0] ls_q, la_q;
  logic [CW-1:0] lc_q;
  logic          lf_q, fv_q, ovf_q;

  // Named events
  logic          compat_eff;
  logic          end_hit;
  logic          last_pass;
  logic          push, pop;
  logic          stk_full, stk_empty;
  logic [EW-1:0] push_data, pop_data;
  logic [AW-1:0] pop_ls, pop_la;
  logic [CW-1:0] pop_lc;
  logic          pop_lf, pop_fv;
  hwl_act_e      act;

  hwloop_mode_dly #(.DLY(MODE_DLY)) u_mode (
    .clk   (clk),
    .rst_n (rst_n),
    .wr_i  (compat_wr_i),
    .val_i (compat_val_i),
    .eff_o (compat_eff)
  );

  assign end_hit   = lf_q && fetch_en_i && (pc_i == la_q);
  assign last_pass = !fv_q && (lc_q <= CW'(1));

  always_comb begin
    if (do_req_i) begin
      act = (!do_forever_i && zero_skips(do_count_i, compat_eff)) ? ACT_SKIP : ACT_START;
    end else if (abort_i) begin
      act = ACT_ABORT;
    end else if (rti_i) begin
      act = ACT_RTI;
    end else if (end_hit) begin
      act = last_pass ? ACT_EXIT : ACT_BRANCH;
    end else begin
      act = ACT_IDLE;
    end
  end

  assign push = (act == ACT_START);
  assign pop  = (act == ACT_ABORT) || (act == ACT_RTI) || (act == ACT_EXIT);

  assign push_data = {ls_q, la_q, lc_q, lf_q, fv_q};
  assign {pop_ls, pop_la, pop_lc, pop_lf, pop_fv} = pop_data;

  hwloop_stack #(.W(EW), .DEPTH(DEPTH)) u_stack (
    .clk         (clk),
    .rst_n       (rst_n),
    .push_i      (push),
    .pop_i       (pop),
    .push_data_i (push_data),
    .top_data_o  (pop_data),
    .full_o      (stk_full),
    .empty_o     (stk_empty)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ls_q  <= '0;
      la_q  <= '0;
      lc_q  <= '0;
      lf_q  <= 1'b0;
      fv_q  <= 1'b0;
      ovf_q <= 1'b0;
    end else begin
      unique case (act)
        ACT_START: begin
          ls_q <= do_start_i;
          la_q <= do_end_i;
          lc_q <= do_forever_i ? '0 : load_count(do_count_i, compat_eff);
          lf_q <= 1'b1;
          fv_q <= do_forever_i;
          if (stk_full) ovf_q <= 1'b1;
        end
        ACT_ABORT, ACT_EXIT: begin
          ls_q <= pop_ls;
          la_q <= pop_la;
          lc_q <= pop_lc;
          lf_q <= pop_lf;
          fv_q <= pop_fv;
        end
        ACT_RTI: begin
          lf_q <= pop_lf;
          fv_q <= pop_fv;
        end
        ACT_BRANCH: begin
          if (!fv_q) lc_q <= lc_q - CW'(1);
        end
        default: ;
      endcase
    end
  end

  assign branch_o       = (act == ACT_BRANCH);
  assign branch_addr_o  = ls_q;
  assign skip_o         = (act == ACT_SKIP);
  assign skip_addr_o    = do_end_i + AW'(1);
  assign exit_o         = (act == ACT_EXIT);
  assign loop_flag_o    = lf_q;
  assign forever_flag_o = fv_q;
  assign cur_end_o      = la_q;
  assign cur_cnt_o      = lc_q;
  assign compat_eff_o   = compat_eff;
  assign overflow_o     = ovf_q;
endmodule

// File: rtl/hwloop_seq_chk.sv
module hwloop_seq_chk #(
  parameter int AW = 16,
  parameter int CW = 24
) (
  input logic          clk,
  input logic          rst_n,
  input logic          do_req_i,
  input logic          do_forever_i,
  input logic          abort_i,
  input logic          compat_wr_i,
  input logic          branch_o,
  input logic          exit_o,
  input logic          skip_o,
  input logic          loop_flag_o,
  input logic          forever_flag_o,
  input logic [AW-1:0] cur_end_o,
  input logic [CW-1:0] cur_cnt_o,
  input logic          compat_eff_o,
  input logic          overflow_o,
  input logic          end_hit
);
  // R4
  branch_on_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_o |-> end_hit && loop_flag_o);

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    branch_o && !forever_flag_o |=> cur_cnt_o == $past(cur_cnt_o) - CW'(1));

  // R5
  exit_last_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    exit_o |-> !forever_flag_o && (cur_cnt_o <= CW'(1)));

  // R2
  forever_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_req_i && do_forever_i |=> loop_flag_o && forever_flag_o);

  // R6
  skip_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    skip_o |=> $stable(loop_flag_o) && $stable(cur_cnt_o) && $stable(cur_end_o));

  // R9
  mode_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(compat_eff_o) |-> $past(compat_wr_i, 3));

  // R10
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow_o |=> overflow_o);

  // R13
  start_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_req_i |-> !branch_o && !exit_o);

  // R11
  abort_no_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i && !do_req_i |-> !branch_o && !exit_o && !skip_o);
endmodule

bind hwloop_seq hwloop_seq_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .do_req_i       (do_req_i),
  .do_forever_i   (do_forever_i),
  .abort_i        (abort_i),
  .compat_wr_i    (compat_wr_i),
  .branch_o       (branch_o),
  .exit_o         (exit_o),
  .skip_o         (skip_o),
  .loop_flag_o    (loop_flag_o),
  .forever_flag_o (forever_flag_o),
  .cur_end_o      (cur_end_o),
  .cur_cnt_o      (cur_cnt_o),
  .compat_eff_o   (compat_eff_o),
  .overflow_o     (overflow_o),
  .end_hit        (end_hit)
);

// File: tb/hwloop_seq_bench.sv
`timescale 1ns/1ps
module hwloop_seq_bench;
  localparam int AW = 16, CW = 24, KW = 16, DEPTH = 4, DLY = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic fetch_en_i = 0, do_req_i = 0, do_forever_i = 0, abort_i = 0, rti_i = 0;
  logic compat_wr_i = 0, compat_val_i = 0;
  logic [AW-1:0] pc_i = '0, do_start_i = '0, do_end_i = '0;
  logic [CW-1:0] do_count_i = '0;
  logic branch_o, skip_o, exit_o, loop_flag_o, forever_flag_o, compat_eff_o, overflow_o;
  logic [AW-1:0] branch_addr_o, skip_addr_o, cur_end_o;
  logic [CW-1:0] cur_cnt_o;

  hwloop_seq #(.AW(AW), .CW(CW), .KW(KW), .DEPTH(DEPTH), .MODE_DLY(DLY)) u_hwloop_seq (
    .clk(clk), .rst_n(rst_n), .fetch_en_i(fetch_en_i), .pc_i(pc_i),
    .do_req_i(do_req_i), .do_forever_i(do_forever_i), .do_start_i(do_start_i),
    .do_end_i(do_end_i), .do_count_i(do_count_i), .abort_i(abort_i), .rti_i(rti_i),
    .compat_wr_i(compat_wr_i), .compat_val_i(compat_val_i),
    .branch_o(branch_o), .branch_addr_o(branch_addr_o), .skip_o(skip_o),
    .skip_addr_o(skip_addr_o), .exit_o(exit_o), .loop_flag_o(loop_flag_o),
    .forever_flag_o(forever_flag_o), .cur_end_o(cur_end_o), .cur_cnt_o(cur_cnt_o),
    .compat_eff_o(compat_eff_o), .overflow_o(overflow_o)
  );

  always #2 clk = ~clk;

  int n_checks = 0, n_fail = 0;
  bit done = 0;

  // Reference model state
  int            m_cyc = 0;
  logic          m_lf = 0, m_fv = 0, m_ovf = 0;
  logic [AW-1:0] m_ls = '0, m_la = '0;
  logic [CW-1:0] m_lc = '0;
  logic          m_cold = 0, m_cnew = 0;
  int            m_wcyc = -100;
  int            m_sp = 0;
  logic [AW-1:0] s_ls [DEPTH];
  logic [AW-1:0] s_la [DEPTH];
  logic [CW-1:0] s_lc [DEPTH];
  logic          s_lf [DEPTH];
  logic          s_fv [DEPTH];
  string         last_tag = "R1";

  function automatic logic mode_now();
    return (m_cyc >= m_wcyc + DLY) ? m_cnew : m_cold;
  endfunction

  // Passes a counted loop runs, per R7/R8.
  function automatic logic [CW-1:0] exp_passes(input logic [CW-1:0] raw, input logic cm);
    int unsigned r, low;
    r = int'(raw);
    if (!cm) return raw;
    low = r % (1 << KW);
    if (low == 0) return CW'(1 << KW);
    return CW'(low);
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic model_pop(input bit flags_only);
    logic [AW-1:0] a, b; logic [CW-1:0] c; logic f, v;
    if (m_sp > 0) begin
      m_sp--;
      a = s_ls[m_sp]; b = s_la[m_sp]; c = s_lc[m_sp]; f = s_lf[m_sp]; v = s_fv[m_sp];
    end else begin
      a = '0; b = '0; c = '0; f = 0; v = 0;
    end
    m_lf = f; m_fv = v;
    if (!flags_only) begin m_ls = a; m_la = b; m_lc = c; end
  endtask

  task automatic step(input logic fe, input logic [AW-1:0] pc, input logic req, input logic frv,
                      input logic [AW-1:0] st, input logic [AW-1:0] en, input logic [CW-1:0] cnt,
                      input logic ab, input logic rt, input logic cw, input logic cv);
    logic cm, hit, e_br, e_ex, e_sk;
    @(negedge clk);
    chk(last_tag, "loop_flag", 32'(loop_flag_o), 32'(m_lf));
    chk(last_tag, "forever_flag", 32'(forever_flag_o), 32'(m_fv));
    chk(last_tag, "cur_end", 32'(cur_end_o), 32'(m_la));
    chk(last_tag, "cur_cnt", 32'(cur_cnt_o), 32'(m_lc));
    chk("R10", "overflow", 32'(overflow_o), 32'(m_ovf));
    chk("R9", "compat_eff", 32'(compat_eff_o), 32'(mode_now()));
    fetch_en_i = fe; pc_i = pc; do_req_i = req; do_forever_i = frv; do_start_i = st;
    do_end_i = en; do_count_i = cnt; abort_i = ab; rti_i = rt; compat_wr_i = cw; compat_val_i = cv;
    #1;
    cm = mode_now();
    hit = m_lf && fe && (pc == m_la);
    e_sk = req && !frv && !cm && (cnt == '0);
    e_br = !req && !ab && !rt && hit && (m_fv || m_lc > 1);
    e_ex = !req && !ab && !rt && hit && !(m_fv || m_lc > 1);
    chk("R4", "branch", 32'(branch_o), 32'(e_br));
    if (e_br) chk("R4", "branch_addr", 32'(branch_addr_o), 32'(m_ls));
    chk("R5", "exit", 32'(exit_o), 32'(e_ex));
    chk("R6", "skip", 32'(skip_o), 32'(e_sk));
    if (e_sk) chk("R6", "skip_addr", 32'(skip_addr_o), 32'(AW'(en + 1)));
    if (req) begin
      if (e_sk) last_tag = "R6";
      else begin
        if (m_sp < DEPTH) begin
          s_ls[m_sp] = m_ls; s_la[m_sp] = m_la; s_lc[m_sp] = m_lc;
          s_lf[m_sp] = m_lf; s_fv[m_sp] = m_fv; m_sp++;
          last_tag = frv ? "R2" : (cm ? "R8" : "R7");
        end else begin
          m_ovf = 1; last_tag = "R10";
        end
        m_ls = st; m_la = en; m_lf = 1; m_fv = frv;
        m_lc = frv ? '0 : exp_passes(cnt, cm);
      end
    end else if (ab) begin
      model_pop(0); last_tag = "R11";
    end else if (rt) begin
      model_pop(1); last_tag = "R12";
    end else if (e_ex) begin
      model_pop(0); last_tag = "R3";
    end else if (e_br) begin
      if (!m_fv) m_lc = m_lc - 1;
      last_tag = "R4";
    end else begin
      last_tag = "R13";
    end
    if (cw) begin
      m_cold = cm; m_cnew = cv; m_wcyc = m_cyc;
    end
    m_cyc++;
  endtask

  task automatic idle();
    step(0, '0, 0, 0, '0, '0, '0, 0, 0, 0, 0);
  endtask
  task automatic start(input logic frv, input logic [AW-1:0] st, input logic [AW-1:0] en, input logic [CW-1:0] cnt);
    step(0, '0, 1, frv, st, en, cnt, 0, 0, 0, 0);
  endtask
  task automatic fetch(input logic [AW-1:0] pc);
    step(1, pc, 0, 0, '0, '0, '0, 0, 0, 0, 0);
  endtask
  task automatic abort1();
    step(0, '0, 0, 0, '0, '0, '0, 1, 0, 0, 0);
  endtask
  task automatic setmode(input logic v);
    step(0, '0, 0, 0, '0, '0, '0, 0, 0, 1, v);
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  initial begin
    #800000;
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      report();
      $finish;
    end
  end

  initial begin
    int nbr;
    void'($urandom(32'h5eed_1234));
    repeat (4) @(negedge clk);
    rst_n = 1;
    // R1: reset state is checked by the first step
    idle();
    chk("R1", "branch idle", 32'(branch_o), 0);
    // R6: normal-mode zero count skips
    step(0, '0, 1, 0, 16'h0041, 16'h0040, '0, 0, 0, 0, 0);
    chk("R6", "skip zero", 32'(skip_o), 1);
    // R3 nesting
    start(0, 16'h0010, 16'h0020, 24'd2);
    start(0, 16'h0012, 16'h0018, 24'd2);
    fetch(16'h0018);
    fetch(16'h0018);
    chk("R5", "inner exit", 32'(exit_o), 1);
    idle();
    chk("R3", "outer end restored", 32'(cur_end_o), 32'h20);
    chk("R3", "outer count restored", 32'(cur_cnt_o), 2);
    fetch(16'h0020);
    fetch(16'h0020);
    idle();
    chk("R3", "all loops done", 32'(loop_flag_o), 0);
    // R7: full 24-bit count
    start(0, 16'h0029, 16'h0030, 24'hFFFFFF);
    idle();
    chk("R7", "max load", 32'(cur_cnt_o), 32'hFFFFFF);
    fetch(16'h0030);
    idle();
    chk("R7", "max decrement", 32'(cur_cnt_o), 32'hFFFFFE);
    abort1();
    idle();
    chk("R11", "abort clears", 32'(loop_flag_o), 0);
    // R10: overflow with DEPTH+1 nested starts, then unwind past empty
    for (int i = 0; i <= DEPTH; i++) start(i[0], AW'(16'h100 + i), AW'(16'h180 + i), CW'(i + 1));
    idle();
    chk("R10", "overflow set", 32'(overflow_o), 1);
    for (int i = 0; i <= DEPTH + 1; i++) abort1();
    idle();
    chk("R13", "empty pop zero", 32'(loop_flag_o), 0);
    // R12: rti restores flags only
    start(1, 16'h0049, 16'h0050, '0);
    step(0, '0, 0, 0, '0, '0, '0, 0, 1, 0, 0);
    idle();
    chk("R12", "rti flag", 32'(loop_flag_o), 0);
    chk("R12", "rti keeps end", 32'(cur_end_o), 32'h50);
    // R13: start beats an end match
    start(0, 16'h005A, 16'h0060, 24'd3);
    step(1, 16'h0060, 1, 0, 16'h0068, 16'h0070, 24'd5, 0, 0, 0, 0);
    chk("R13", "no branch on start", 32'(branch_o), 0);
    idle();
    chk("R13", "new end", 32'(cur_end_o), 32'h70);
    abort1(); abort1();
    // R9 / R8: mode change delay and 65536 passes
    setmode(1);
    step(0, '0, 1, 0, 16'h0079, 16'h007F, '0, 0, 0, 0, 0);
    chk("R9", "old mode still skips", 32'(skip_o), 1);
    idle();
    start(0, 16'h007A, 16'h0080, '0);
    chk("R9", "new mode no skip", 32'(skip_o), 0);
    idle();
    chk("R8", "zero loads 65536", 32'(cur_cnt_o), 32'h10000);
    nbr = 0;
    for (int i = 0; i < 70000; i++) begin
      fetch(16'h0080);
      if (branch_o) nbr++;
      if (exit_o) break;
    end
    chk("R8", "passes of zero count", 32'(nbr + 1), 32'd65536);
    start(0, 16'h0081, 16'h0090, 24'hFFFFFF);
    idle();
    chk("R8", "compat max load", 32'(cur_cnt_o), 32'hFFFF);
    abort1();
    idle(); idle(); idle();
    setmode(0);
    repeat (4) idle();
    // Random phase
    for (int n = 0; n < 4000; n++) begin
      logic fe, req, frv, ab, rt, cw;
      logic [AW-1:0] pc, en;
      logic [CW-1:0] cnt;
      fe  = ($urandom % 4) != 0;
      pc  = ($urandom % 2) ? m_la : AW'($urandom % 64);
      req = ($urandom % 8) == 0;
      frv = ($urandom % 4) == 0;
      en  = AW'($urandom % 64);
      cnt = ($urandom % 16 == 0) ? CW'($urandom) : CW'($urandom % 5);
      ab  = ($urandom % 30) == 0;
      rt  = ($urandom % 40) == 0;
      cw  = (($urandom % 40) == 0) && (m_cyc >= m_wcyc + DLY + 1);
      step(fe, pc, req, frv, AW'(en - 3), en, cnt, ab, rt, cw, 1'($urandom));
    end
    idle();
    done = 1;
    report();
    $finish;
  end
endmodule